// File: doc/BRIEF.md
# External Bus Interface Unit

This unit sits between a processor's internal memory request port and an external asynchronous memory bus. Each accepted request becomes one or two external bus cycles. Every cycle has an address phase with ALE high, a strobe phase with RD or WR low, and an end phase with the strobes released. The external data path is 16 bits or 8 bits wide. A static width input selects it, and that input also sets which data lane carries which byte.

Slow devices can stretch the strobe phase by pulling RDY low. On the 8-bit bus, a selected chip-select area can use the low data lane to carry the low address byte during the address phase. Reads of the internal memory area still run a bus cycle, but the external lanes are not sampled, and RD can be kept high for those reads.

A bus master outside the chip can take the bus with HOLD. The unit answers with HLDA and floats its address, strobe and data pins one cycle later. When HOLD is released, it drives those pins again one cycle after HLDA returns high.

Top module: `ext_bus_unit`

## Requirements
- R1: `ext_rd_no` is low only in the strobe phase of an external read, and `ext_wr_no` is low only in the strobe phase of a write. The two are never low together, and both are high in the address and end phases.
- R2: `ext_bhe_no` is low in every phase of a bus cycle that moves the odd-address byte, and high otherwise. A word request at an even address with `byte_mode_i`=0 takes one cycle with address bit 0 low and `ext_bhe_no` low.
- R3: `ext_ale_o` is high for exactly the one address-phase cycle of each bus cycle. `ext_addr_o` holds the cycle's byte address from the address phase through the end phase.
- R4: With `byte_mode_i`=0, even-address bytes travel on the low lane (`ext_dl_*`) and odd-address bytes on the high lane (`ext_dh_*`), and a word at an even address uses both lanes. With `byte_mode_i`=1, every byte travels on the low lane. Read data is returned as `rsp_rdata_o[7:0]` = byte at the request address and `rsp_rdata_o[15:8]` = byte at address+1 (zero for byte requests).
- R5: For a read with `req_internal_i`=1, the external lanes are not sampled and `rsp_rdata_o` is zero. When `rd_disable_i`=1, `ext_rd_no` also stays high through such a read.
- R6: When `byte_mode_i`=1, `mux_enable_i`=1 and the request carried `req_mux_area_i`=1, the low lane drives the cycle's address bits 7:0 with `ext_data_oe_o`=01 during the address phase. In the strobe phase it carries write data or is released for a read. Otherwise no lane is driven in the address phase.
- R7: HOLD low (`hold_ni`=0) is acted on only while the unit is idle, and it takes priority over a pending request. `hlda_no` goes low the next cycle. One cycle after that, `bus_oe_o` and `ext_data_oe_o` go low. No request is accepted while the bus is held.
- R8: When `hold_ni` returns high, `hlda_no` goes high the next cycle with `bus_oe_o` still low, and `bus_oe_o` goes high one cycle after that.
- R9: While `rdy_i` is low in the strobe phase, the cycle stays in the strobe phase with its strobes, address and lanes unchanged. The end phase follows the clock edge at which `rdy_i` is seen high.
- R10: A word request splits into two byte cycles, first at the request address and then at address+1, when `byte_mode_i`=1 or the address is odd. The two bytes are assembled and a single response is given.
- R11: A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. ALE follows in the next cycle. `rsp_valid_o` is high for exactly the end-phase cycle of the last bus cycle. `req_ready_o` is high again in the following idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | ADDR_W | Byte address of the request |
| req_word_i | input | 1 | 1: two bytes (address, address+1); 0: one byte |
| req_write_i | input | 1 | 1: write, 0: read |
| req_wdata_i | input | 2*BYTE_W | Write data, low byte to the request address |
| req_internal_i | input | 1 | Request targets the internal memory area |
| req_mux_area_i | input | 1 | Request targets the chip-select area selected for multiplexing |
| req_ready_o | output | 1 | Request can be taken this cycle |
| rsp_valid_o | output | 1 | Request completes this cycle |
| rsp_rdata_o | output | 2*BYTE_W | Assembled read data |
| byte_mode_i | input | 1 | 1: 8-bit external bus, 0: 16-bit |
| rd_disable_i | input | 1 | Keep RD high for internal-area reads |
| mux_enable_i | input | 1 | Allow address on the low lane (8-bit bus only) |
| ext_addr_o | output | ADDR_W | External byte address |
| ext_ale_o | output | 1 | Address latch enable |
| ext_rd_no | output | 1 | Read strobe, active low |
| ext_wr_no | output | 1 | Write strobe, active low |
| ext_bhe_no | output | 1 | Odd byte enable, active low |
| bus_oe_o | output | 1 | Drive enable for address, RD, WR and BHE pins |
| ext_dl_o | output | BYTE_W | Low data lane out |
| ext_dh_o | output | BYTE_W | High data lane out |
| ext_data_oe_o | output | 2 | Lane drive enables, bit 0 low lane, bit 1 high lane |
| ext_dl_i | input | BYTE_W | Low data lane in |
| ext_dh_i | input | BYTE_W | High data lane in |
| rdy_i | input | 1 | Ready, low stretches the strobe phase |
| hold_ni | input | 1 | Bus hold request, active low |
| hlda_no | output | 1 | Hold acknowledge, active low |

## Verification
The bench runs the same request kinds on both bus widths. It covers even and odd byte reads, even and odd word reads, and word and byte writes that are read back through a pin-level memory model. These cases separate the lane choice, the BHE level and the one-cycle word from the two-cycle split. Internal-area reads are run with the RD suppression both off and on, which tells a missed sample apart from a suppressed strobe. Stalls of different lengths check that RDY freezes the strobe phase. A multiplexed write and read on the 8-bit bus, compared with a request outside the selected area, shows the address byte appearing on the lane only when all three conditions hold. A hold sequence with a request left waiting checks that HOLD has priority, that nothing is accepted while the bus is held, and that the pins float and return one cycle after each HLDA edge.

// File: rtl/ebu_pkg.sv
package ebu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STRB,
    ST_END,
    ST_HACK,
    ST_HFLT,
    ST_HREL
  } bus_st_e;

  typedef struct packed {
    logic odd;   // current cycle moves an odd-address byte
    logic both;  // current cycle moves a full word on both lanes
    logic two;   // request needs two byte cycles
  } part_t;
endpackage

// File: rtl/ebu_split.sv
module ebu_split
  import ebu_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              word_i,
  input  logic              byte_mode_i,
  input  logic              part_i,
  output logic [ADDR_W-1:0] part_addr_o,
  output part_t             part_o
);
  always_comb begin
    part_o.two  = word_i && (byte_mode_i || addr_i[0]);
    part_o.both = word_i && !part_o.two;
    part_addr_o = part_i ? addr_i + ADDR_W'(1) : addr_i;
    part_o.odd  = part_addr_o[0];
  end
endmodule

// File: rtl/ebu_seq.sv
module ebu_seq
  import ebu_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_valid_i,
  input  logic    hold_ni,
  input  logic    rdy_i,
  input  logic    two_i,
  output bus_st_e st_o,
  output logic    part_o,
  output logic    ready_o,
  output logic    last_o
);
  assign ready_o = (st_o == ST_IDLE) && hold_ni;
  assign last_o  = !(two_i && !part_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_o   <= ST_IDLE;
      part_o <= 1'b0;
    end else begin
      case (st_o)
        ST_IDLE: begin
          if (!hold_ni) st_o <= ST_HACK;
          else if (req_valid_i) begin
            st_o   <= ST_ADDR;
            part_o <= 1'b0;
          end
        end
        ST_ADDR: st_o <= ST_STRB;
        ST_STRB: if (rdy_i) st_o <= ST_END;
        ST_END: begin
          if (!last_o) begin
            st_o   <= ST_ADDR;
            part_o <= 1'b1;
          end else st_o <= ST_IDLE;
        end
        ST_HACK: st_o <= ST_HFLT;
        ST_HFLT: if (hold_ni) st_o <= ST_HREL;
        ST_HREL: st_o <= ST_IDLE;
        default: st_o <= ST_IDLE;
      endcase
    end
  end

  AST_RDY_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_o == ST_STRB && !rdy_i) |=> (st_o == ST_STRB)); // R9
  AST_HOLD_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_o == ST_HACK) |-> ($past(st_o) == ST_IDLE)); // R7
  AST_SPLIT_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_o == ST_END && two_i && !part_o) |=> (st_o == ST_ADDR && part_o)); // R10
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_o == ST_END && last_o) |=> (st_o == ST_IDLE)); // R11
endmodule

// File: rtl/ebu_lanes.sv
module ebu_lanes
  import ebu_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                byte_mode_i,
  input  part_t               part_i,
  input  logic                part_idx_i,
  input  logic [2*BYTE_W-1:0] wdata_i,
  input  logic [BYTE_W-1:0]   addr_byte_i,
  input  logic                mux_on_i,
  input  logic                addr_ph_i,
  input  logic                data_ph_i,
  input  logic                write_i,
  input  logic                clear_i,
  input  logic                cap_i,
  input  logic                sample_i,
  input  logic [BYTE_W-1:0]   dl_i,
  input  logic [BYTE_W-1:0]   dh_i,
  output logic [BYTE_W-1:0]   dl_o,
  output logic [BYTE_W-1:0]   dh_o,
  output logic [1:0]          oe_o,
  output logic [2*BYTE_W-1:0] rdata_o
);
  localparam int DATA_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] wbyte, rbyte;
  logic              use_hi;

  assign use_hi = !byte_mode_i && part_i.odd;
  assign wbyte  = part_idx_i ? wdata_i[DATA_W-1:BYTE_W] : wdata_i[BYTE_W-1:0];
  assign rbyte  = use_hi ? dh_i : dl_i;

  always_comb begin
    dl_o = '0;
    dh_o = '0;
    oe_o = 2'b00;
    if (addr_ph_i && mux_on_i) begin
      dl_o = addr_byte_i;
      oe_o = 2'b01;
    end else if (data_ph_i && write_i) begin
      if (part_i.both) begin
        dl_o = wdata_i[BYTE_W-1:0];
        dh_o = wdata_i[DATA_W-1:BYTE_W];
        oe_o = 2'b11;
      end else if (use_hi) begin
        dh_o = wbyte;
        oe_o = 2'b10;
      end else begin
        dl_o = wbyte;
        oe_o = 2'b01;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (clear_i) rdata_o <= '0;
    else if (cap_i && sample_i) begin
      if (part_i.both) rdata_o <= {dh_i, dl_i};
      else if (part_idx_i) rdata_o[DATA_W-1:BYTE_W] <= rbyte;
      else rdata_o[BYTE_W-1:0] <= rbyte;
    end
  end

  AST_INT_NO_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !sample_i) |=> $stable(rdata_o)); // R5
  AST_READ_LANES_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_ph_i && !write_i) |-> (oe_o == 2'b00)); // R6
endmodule

// File: rtl/ext_bus_unit.sv
module ext_bus_unit
  import ebu_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic                req_word_i,
  input  logic                req_write_i,
  input  logic [2*BYTE_W-1:0] req_wdata_i,
  input  logic                req_internal_i,
  input  logic                req_mux_area_i,
  output logic                req_ready_o,
  output logic                rsp_valid_o,
  output logic [2*BYTE_W-1:0] rsp_rdata_o,
  input  logic                byte_mode_i,
  input  logic                rd_disable_i,
  input  logic                mux_enable_i,
  output logic [ADDR_W-1:0]   ext_addr_o,
  output logic                ext_ale_o,
  output logic                ext_rd_no,
  output logic                ext_wr_no,
  output logic                ext_bhe_no,
  output logic                bus_oe_o,
  output logic [BYTE_W-1:0]   ext_dl_o,
  output logic [BYTE_W-1:0]   ext_dh_o,
  output logic [1:0]          ext_data_oe_o,
  input  logic [BYTE_W-1:0]   ext_dl_i,
  input  logic [BYTE_W-1:0]   ext_dh_i,
  input  logic                rdy_i,
  input  logic                hold_ni,
  output logic                hlda_no
);
  localparam int DATA_W = 2 * BYTE_W;

  bus_st_e             st;
  part_t               pinfo;
  logic                part_idx, last, fire, busy;
  logic [ADDR_W-1:0]   q_addr, part_addr;
  logic [DATA_W-1:0]   q_wdata;
  logic                q_word, q_write, q_int, q_mux;

  assign fire = req_valid_i && req_ready_o;
  assign busy = (st == ST_ADDR) || (st == ST_STRB) || (st == ST_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_addr  <= '0;
      q_wdata <= '0;
      q_word  <= 1'b0;
      q_write <= 1'b0;
      q_int   <= 1'b0;
      q_mux   <= 1'b0;
    end else if (fire) begin
      q_addr  <= req_addr_i;
      q_wdata <= req_wdata_i;
      q_word  <= req_word_i;
      q_write <= req_write_i;
      q_int   <= req_internal_i;
      q_mux   <= req_mux_area_i;
    end
  end

  ebu_split #(.ADDR_W(ADDR_W)) u_split (
    .addr_i      (q_addr),
    .word_i      (q_word),
    .byte_mode_i (byte_mode_i),
    .part_i      (part_idx),
    .part_addr_o (part_addr),
    .part_o      (pinfo)
  );

  ebu_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .hold_ni     (hold_ni),
    .rdy_i       (rdy_i),
    .two_i       (pinfo.two),
    .st_o        (st),
    .part_o      (part_idx),
    .ready_o     (req_ready_o),
    .last_o      (last)
  );

  ebu_lanes #(.BYTE_W(BYTE_W)) u_lanes (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_mode_i (byte_mode_i),
    .part_i      (pinfo),
    .part_idx_i  (part_idx),
    .wdata_i     (q_wdata),
    .addr_byte_i (part_addr[BYTE_W-1:0]),
    .mux_on_i    (byte_mode_i && mux_enable_i && q_mux),
    .addr_ph_i   (st == ST_ADDR),
    .data_ph_i   ((st == ST_STRB) || (st == ST_END)),
    .write_i     (q_write),
    .clear_i     (fire),
    .cap_i       ((st == ST_STRB) && rdy_i && !q_write),
    .sample_i    (!q_int),
    .dl_i        (ext_dl_i),
    .dh_i        (ext_dh_i),
    .dl_o        (ext_dl_o),
    .dh_o        (ext_dh_o),
    .oe_o        (ext_data_oe_o),
    .rdata_o     (rsp_rdata_o)
  );

  assign ext_addr_o  = part_addr;
  assign ext_ale_o   = (st == ST_ADDR);
  assign ext_rd_no   = !((st == ST_STRB) && !q_write && !(q_int && rd_disable_i));
  assign ext_wr_no   = !((st == ST_STRB) && q_write);
  assign ext_bhe_no  = busy ? !(pinfo.odd || pinfo.both) : 1'b1;
  assign bus_oe_o    = !((st == ST_HFLT) || (st == ST_HREL));
  assign hlda_no     = !((st == ST_HACK) || (st == ST_HFLT));
  assign rsp_valid_o = (st == ST_END) && last;

  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ext_rd_no && !ext_wr_no)); // R1
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ext_ale_o) |-> $stable(ext_addr_o)); // R3
  AST_FLOAT_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hlda_no) |=> (!bus_oe_o && ext_data_oe_o == 2'b00)); // R7
  AST_DRIVE_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hlda_no) |=> bus_oe_o); // R8
  AST_RSP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R11
endmodule

// File: tb/ext_bus_unit_test.sv
`timescale 1ns/1ps
module ext_bus_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_word = 1'b0, req_write = 1'b0;
  logic        req_int = 1'b0, req_mux = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic        byte_mode = 1'b0, rd_dis = 1'b0, mux_en = 1'b0;
  logic [23:0] ext_addr;
  logic        ale, rd_n, wr_n, bhe_n, bus_oe, hlda_n;
  logic [7:0]  dl_out, dh_out, dl_in, dh_in;
  logic [1:0]  data_oe;
  logic        rdy = 1'b1, hold_n = 1'b1;
  logic [7:0]  ext_mem [256];
  logic [7:0]  ref_mem [256];
  int          total = 0, bad = 0;

  always #4 clk = ~clk;

  ext_bus_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_word_i(req_word),
    .req_write_i(req_write), .req_wdata_i(req_wdata), .req_internal_i(req_int),
    .req_mux_area_i(req_mux), .req_ready_o(req_ready), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .byte_mode_i(byte_mode), .rd_disable_i(rd_dis),
    .mux_enable_i(mux_en), .ext_addr_o(ext_addr), .ext_ale_o(ale),
    .ext_rd_no(rd_n), .ext_wr_no(wr_n), .ext_bhe_no(bhe_n), .bus_oe_o(bus_oe),
    .ext_dl_o(dl_out), .ext_dh_o(dh_out), .ext_data_oe_o(data_oe),
    .ext_dl_i(dl_in), .ext_dh_i(dh_in), .rdy_i(rdy), .hold_ni(hold_n),
    .hlda_no(hlda_n)
  );

  // pin-level external memory
  always_comb begin
    dl_in = 8'hEE;
    dh_in = 8'hEE;
    if (!rd_n) begin
      if (byte_mode) dl_in = ext_mem[ext_addr[7:0]];
      else begin
        dl_in = ext_mem[{ext_addr[7:1], 1'b0}];
        dh_in = ext_mem[{ext_addr[7:1], 1'b1}];
      end
    end
  end

  always @(posedge clk) begin
    if (bus_oe && !wr_n) begin
      if (data_oe[0]) ext_mem[byte_mode ? ext_addr[7:0] : {ext_addr[7:1], 1'b0}] <= dl_out;
      if (data_oe[1]) ext_mem[{ext_addr[7:1], 1'b1}] <= dh_out;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic txn(input logic [23:0] a, input logic wd, input logic wr,
                     input logic [15:0] wv, input logic intl, input logic mx,
                     input int stall);
    int          n;
    logic [15:0] expd;
    logic [23:0] pa;
    logic        both, rd_exp;
    logic [7:0]  bv;
    n = (wd && (byte_mode || a[0])) ? 2 : 1;
    both = wd && (n == 1);
    if (wr || intl) expd = '0;
    else expd = wd ? {ref_mem[a[7:0] + 8'd1], ref_mem[a[7:0]]} : {8'h00, ref_mem[a[7:0]]};
    if (wr) begin
      ref_mem[a[7:0]] = wv[7:0];
      if (wd) ref_mem[a[7:0] + 8'd1] = wv[15:8];
    end
    rd_exp = !(!wr && !(intl && rd_dis));
    chk("R11 ready before request", req_ready, 1'b1);
    req_addr = a; req_word = wd; req_write = wr; req_wdata = wv;
    req_int = intl; req_mux = mx; req_valid = 1'b1;
    for (int p = 0; p < n; p++) begin
      pa = a + 24'(p);
      bv = (p == 1) ? wv[15:8] : wv[7:0];
      @(negedge clk);
      req_valid = 1'b0;
      chk("R3 ale in address phase", ale, 1'b1);
      chk("R10 address of part", ext_addr, pa);
      chk("R2 bhe level", bhe_n, !(pa[0] || both));
      chk("R1 rd high in address phase", rd_n, 1'b1);
      chk("R1 wr high in address phase", wr_n, 1'b1);
      if (byte_mode && mux_en && mx) begin
        chk("R6 address on low lane oe", data_oe, 2'b01);
        chk("R6 address byte on low lane", dl_out, pa[7:0]);
      end else chk("R6 no lane in address phase", data_oe, 2'b00);
      for (int s = 0; s <= stall; s++) begin
        @(negedge clk);
        chk("R9 rd in strobe phase", rd_n, rd_exp);
        chk("R1 wr in strobe phase", wr_n, !wr);
        chk("R3 ale low after address phase", ale, 1'b0);
        chk("R3 address held", ext_addr, pa);
        chk("R2 bhe held", bhe_n, !(pa[0] || both));
        chk("R11 no response in strobe", rsp_valid, 1'b0);
        if (wr) begin
          if (both) begin
            chk("R4 word lanes oe", data_oe, 2'b11);
            chk("R4 word lanes data", {dh_out, dl_out}, wv);
          end else if (!byte_mode && pa[0]) begin
            chk("R4 high lane oe", data_oe, 2'b10);
            chk("R4 high lane data", dh_out, bv);
          end else begin
            chk("R4 low lane oe", data_oe, 2'b01);
            chk("R4 low lane data", dl_out, bv);
          end
        end else chk("R6 lanes released for read", data_oe, 2'b00);
        rdy = (s == stall);
      end
      @(negedge clk);
      rdy = 1'b1;
      chk("R1 rd high in end phase", rd_n, 1'b1);
      chk("R1 wr high in end phase", wr_n, 1'b1);
      chk("R3 address held in end phase", ext_addr, pa);
      chk("R11 response on last end phase", rsp_valid, (p == n - 1));
      if (p == n - 1 && !wr) chk(intl ? "R5 internal read data" : "R10 read data", rsp_rdata, expd);
    end
    @(negedge clk);
    chk("R11 response one cycle", rsp_valid, 1'b0);
    chk("R11 ready after response", req_ready, 1'b1);
    chk("R3 ale idle", ale, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R11 watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      ext_mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 hlda after reset", hlda_n, 1'b1);
    chk("R1 rd after reset", rd_n, 1'b1);
    chk("R1 wr after reset", wr_n, 1'b1);
    chk("R3 ale after reset", ale, 1'b0);
    chk("R8 pins driven after reset", bus_oe, 1'b1);
    chk("R11 no response after reset", rsp_valid, 1'b0);

    // 16-bit bus
    byte_mode = 1'b0;
    txn(24'h120010, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 0);   // R4 even byte, low lane
    txn(24'h120011, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 0);   // R4 odd byte, high lane
    txn(24'h120020, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 0);   // R2 single word cycle
    txn(24'h120031, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 2);   // R10 split, R9 stall
    txn(24'h120040, 1'b1, 1'b1, 16'hBEEF, 1'b0, 1'b0, 0);
    txn(24'h120045, 1'b0, 1'b1, 16'h005A, 1'b0, 1'b0, 1);
    txn(24'h120040, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 0);
    txn(24'h120044, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 0);
    txn(24'h120047, 1'b1, 1'b1, 16'hC3A5, 1'b0, 1'b0, 0); // R10 odd word write
    txn(24'h120047, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 3);
    rd_dis = 1'b0;
    txn(24'h000050, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0, 0);   // R5 strobe pulses, no sample
    rd_dis = 1'b1;
    txn(24'h000050, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0, 1);   // R5 strobe held high
    rd_dis = 1'b0;

    // 8-bit bus
    byte_mode = 1'b1;
    txn(24'h120060, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 0);   // R10 word split on 8-bit bus
    txn(24'h120063, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 0);   // R4 odd byte on low lane
    mux_en = 1'b1;
    txn(24'h120071, 1'b1, 1'b1, 16'h9D2E, 1'b0, 1'b1, 0); // R6 multiplexed write
    txn(24'h120071, 1'b1, 1'b0, 16'h0, 1'b0, 1'b1, 1);   // R6 multiplexed read
    txn(24'h120080, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 0);   // R6 area not selected
    mux_en = 1'b0;
    txn(24'h120072, 1'b0, 1'b0, 16'h0, 1'b0, 1'b1, 0);   // R6 mux disabled
    byte_mode = 1'b0;

    // hold handover with a request waiting
    hold_n = 1'b0;
    req_addr = 24'h120010; req_word = 1'b0; req_write = 1'b0; req_int = 1'b0;
    req_mux = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    chk("R7 hlda low", hlda_n, 1'b0);
    chk("R7 pins still driven", bus_oe, 1'b1);
    chk("R7 hold beats request", ale, 1'b0);
    @(negedge clk);
    chk("R7 pins floated", bus_oe, 1'b0);
    chk("R7 lanes floated", data_oe, 2'b00);
    chk("R7 hlda held low", hlda_n, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 no accept in hold", ale, 1'b0);
      chk("R7 not ready in hold", req_ready, 1'b0);
      chk("R7 still floated", bus_oe, 1'b0);
    end
    req_valid = 1'b0;
    hold_n = 1'b1;
    @(negedge clk);
    chk("R8 hlda high", hlda_n, 1'b1);
    chk("R8 pins still floated", bus_oe, 1'b0);
    @(negedge clk);
    chk("R8 pins driven again", bus_oe, 1'b1);
    chk("R8 ready again", req_ready, 1'b1);
    txn(24'h120011, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule